// File: doc/BRIEF.md
# Front panel power LED sequencer

This block turns the platform's sleep-state status lines and a "message pending" flag into the two select lines of a bicolour front panel LED. One select lights the green element and the other lights the yellow element. The block recognises five conditions: powered off, running, running with a pending message, sleeping, and sleeping with a pending message. It shows each as dark, steady green, blinking green, steady yellow or blinking yellow.

All three status inputs are asynchronous to the block clock. Each passes through a synchroniser chain. A registered decoder then picks the current condition. A blink timer produces a 50% duty square wave whose half period is a parameter; the default gives about 1 Hz from a 50 MHz clock. Whenever the decoded condition changes, the timer restarts in its lit phase, so the first flash after a change is always full length. The LED selects leave the block from flops. A parameter chooses whether they are active high or active low.

Top module: `pled_sequencer`

## Requirements
- R1: While the active-low S5 line is low (0), both LED selects are inactive, whatever the S3 line and the message flag hold.
- R2: With S5 high, S3 low and no message pending, the green select is held active and the yellow select inactive, with no blinking.
- R3: With S5 high, S3 low and a message pending, the green select blinks and the yellow select stays inactive.
- R4: With S5 high, S3 high and no message pending, the yellow select is held active and the green select inactive, with no blinking.
- R5: With S5 high, S3 high and a message pending, the yellow select blinks and the green select stays inactive.
- R6: The S3 line picks the colour: S3 high gives yellow, S3 low gives green. The two selects are never active in the same cycle.
- R7: A blinking select is active for exactly BLINK_HALF_CYC clock cycles and then inactive for exactly BLINK_HALF_CYC cycles, repeating.
- R8: After any change of the decoded condition, a blinking select begins with a full active interval of BLINK_HALF_CYC cycles.
- R9: An input change is visible on the LED selects exactly SYNC_STAGES+2 rising clock edges after it is applied; one edge earlier, the selects still show the previous condition.
- R10: During reset and after it is released, both selects are inactive until a running or sleeping condition has propagated through the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slp3_i | input | 1 | Suspend-to-RAM status line, high while sleeping (asynchronous) |
| slp5_n_i | input | 1 | Soft-off status line, low while off (asynchronous) |
| msg_pend_i | input | 1 | Message pending flag (asynchronous) |
| led_grn_o | output | 1 | Green element select (polarity set by LED_ACTIVE_HIGH) |
| led_yel_o | output | 1 | Yellow element select (polarity set by LED_ACTIVE_HIGH) |

## Verification
The bench drives the off condition with S3 and the message flag both high. A decoder that lets S3 win over S5 would light yellow there instead of staying dark.

Every condition change is followed sample by sample. This catches a pipeline with one register too many or too few, because the new pattern would appear an edge early or late. It also catches a blink timer that keeps its old phase across a change, because the first lit interval would come out short or start dark.

Long blink windows are checked against the exact half period, so an off-by-one divider shows up as a drifting edge. Random condition sequences mix message-only changes with colour changes, which exposes a decoder that restarts the timer on only some transitions.

// File: rtl/pled_pkg.sv
package pled_pkg;

   typedef enum logic [2:0] {
      PST_OFF     = 3'd0,
      PST_RUN     = 3'd1,
      PST_RUN_MSG = 3'd2,
      PST_SLP     = 3'd3,
      PST_SLP_MSG = 3'd4
   } pwr_state_e;

   function automatic logic st_blinks(pwr_state_e s);
      return (s == PST_RUN_MSG) || (s == PST_SLP_MSG);
   endfunction

   function automatic logic st_green(pwr_state_e s);
      return (s == PST_RUN) || (s == PST_RUN_MSG);
   endfunction

   function automatic logic st_yellow(pwr_state_e s);
      return (s == PST_SLP) || (s == PST_SLP_MSG);
   endfunction

endpackage

// File: rtl/pled_sync.sv
module pled_sync #(
   parameter int          WIDTH   = 3,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      initial $error("pled_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      initial $error("pled_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
      end else begin
         chain_q[0] <= async_i;
         for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/pled_decode.sv
module pled_decode
   import pled_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       s3_i,
   input  logic       s5_n_i,
   input  logic       msg_i,
   output pwr_state_e st_d_o,
   output pwr_state_e st_q_o
);

   pwr_state_e st_d;
   pwr_state_e st_q;

   always_comb begin
      if (!s5_n_i)      st_d = PST_OFF;
      else if (s3_i)    st_d = msg_i ? PST_SLP_MSG : PST_SLP;
      else              st_d = msg_i ? PST_RUN_MSG : PST_RUN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= PST_OFF;
      else        st_q <= st_d;
   end

   assign st_d_o = st_d;
   assign st_q_o = st_q;

   // R1: soft-off dominates S3 and the message flag
   a_r1_s5_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
      !s5_n_i |=> (st_q == PST_OFF));

   // R6: S3 with S5 released selects a sleeping condition
   a_r6_s3_selects_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      (s5_n_i && s3_i) |=> (st_q == PST_SLP || st_q == PST_SLP_MSG));

endmodule

// File: rtl/pled_blink.sv
module pled_blink
   import pled_pkg::*;
#(
   parameter int HALF_CYC = 25_000_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  pwr_state_e st_d_i,
   input  pwr_state_e st_q_i,
   output logic       phase_o
);

   localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

   if (HALF_CYC < 1) begin : g_bad_half
      initial $error("pled_blink: HALF_CYC must be at least 1");
   end

   logic restart;
   logic phase_q;

   assign restart = (st_d_i != st_q_i);

   if (HALF_CYC == 1) begin : g_toggle_only
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       phase_q <= 1'b1;
         else if (restart) phase_q <= 1'b1;
         else              phase_q <= ~phase_q;
      end
   end else begin : g_divider
      localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b1;
         end else if (restart) begin
            cnt_q   <= '0;
            phase_q <= 1'b1;
         end else if (cnt_q == LAST) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
         end else begin
            cnt_q   <= cnt_q + 1'b1;
         end
      end

      // R7: the divider never runs past one half period
      a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q <= LAST);

      // R7: the phase only flips at the end of a half period or on restart
      a_r7_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (!restart && cnt_q != LAST) |=> $stable(phase_q));
   end

   assign phase_o = phase_q;

endmodule

// File: rtl/pled_drive.sv
module pled_drive
   import pled_pkg::*;
#(
   parameter bit ACTIVE_HIGH = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  pwr_state_e st_i,
   input  logic       phase_i,
   output logic       grn_lit_o,
   output logic       yel_lit_o,
   output logic       grn_pin_o,
   output logic       yel_pin_o
);

   logic grn_d, yel_d;
   logic grn_q, yel_q;
   logic show;

   assign show  = !st_blinks(st_i) || phase_i;
   assign grn_d = st_green(st_i)  && show;
   assign yel_d = st_yellow(st_i) && show;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grn_q <= 1'b0;
         yel_q <= 1'b0;
      end else begin
         grn_q <= grn_d;
         yel_q <= yel_d;
      end
   end

   if (ACTIVE_HIGH) begin : g_pol_high
      assign grn_pin_o = grn_q;
      assign yel_pin_o = yel_q;
   end else begin : g_pol_low
      assign grn_pin_o = ~grn_q;
      assign yel_pin_o = ~yel_q;
   end

   assign grn_lit_o = grn_q;
   assign yel_lit_o = yel_q;

   // R6: the two elements are never lit together
   a_r6_never_both: assert property (@(posedge clk) disable iff (!rst_n)
      !(grn_q && yel_q));

   // R1: off leaves the LED dark
   a_r1_off_dark: assert property (@(posedge clk) disable iff (!rst_n)
      (st_i == PST_OFF) |=> (!grn_q && !yel_q));

   // R2: running without a message is steady green
   a_r2_run_green: assert property (@(posedge clk) disable iff (!rst_n)
      (st_i == PST_RUN) |=> (grn_q && !yel_q));

   // R4: sleeping without a message is steady yellow
   a_r4_slp_yellow: assert property (@(posedge clk) disable iff (!rst_n)
      (st_i == PST_SLP) |=> (yel_q && !grn_q));

   // R3: running with a message never lights yellow
   a_r3_runmsg_no_yel: assert property (@(posedge clk) disable iff (!rst_n)
      (st_i == PST_RUN_MSG) |=> !yel_q);

   // R5: sleeping with a message never lights green
   a_r5_slpmsg_no_grn: assert property (@(posedge clk) disable iff (!rst_n)
      (st_i == PST_SLP_MSG) |=> !grn_q);

endmodule

// File: rtl/pled_sequencer.sv
module pled_sequencer
   import pled_pkg::*;
#(
   parameter int SYNC_STAGES     = 2,
   parameter int BLINK_HALF_CYC  = 25_000_000,
   parameter bit LED_ACTIVE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slp3_i,
   input  logic slp5_n_i,
   input  logic msg_pend_i,
   output logic led_grn_o,
   output logic led_yel_o
);

   // bit order in the synchroniser: {msg, s5_n, s3}; reset value means "off"
   localparam logic [2:0] SYNC_RST = 3'b000;

   logic [2:0] raw_in, syn_in;
   pwr_state_e st_d, st_q;
   logic       phase;
   logic       grn_lit, yel_lit;

   assign raw_in = {msg_pend_i, slp5_n_i, slp3_i};

   pled_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (raw_in),
      .sync_o  (syn_in)
   );

   pled_decode u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .s3_i   (syn_in[0]),
      .s5_n_i (syn_in[1]),
      .msg_i  (syn_in[2]),
      .st_d_o (st_d),
      .st_q_o (st_q)
   );

   pled_blink #(
      .HALF_CYC (BLINK_HALF_CYC)
   ) u_blink (
      .clk     (clk),
      .rst_n   (rst_n),
      .st_d_i  (st_d),
      .st_q_i  (st_q),
      .phase_o (phase)
   );

   pled_drive #(
      .ACTIVE_HIGH (LED_ACTIVE_HIGH)
   ) u_drive (
      .clk       (clk),
      .rst_n     (rst_n),
      .st_i      (st_q),
      .phase_i   (phase),
      .grn_lit_o (grn_lit),
      .yel_lit_o (yel_lit),
      .grn_pin_o (led_grn_o),
      .yel_pin_o (led_yel_o)
   );

   // R8: a fresh non-off condition is shown lit in the following cycle
   a_r8_restart_lit: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != $past(st_q) && st_q != PST_OFF) |=> (grn_lit || yel_lit));

endmodule

// File: tb/pled_sequencer_tb_top.sv
module pled_sequencer_tb_top;

   localparam int SYNC = 2;
   localparam int HALF = 5;
   localparam int LAT  = SYNC + 2;
   localparam int WIN  = LAT + 4 * HALF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic slp3 = 1'b0, slp5_n = 1'b0, msg = 1'b0;
   logic led_grn, led_yel;

   int checks = 0;
   int failures = 0;
   int cur_st = 0;

   always #10 clk = ~clk;

   pled_sequencer #(
      .SYNC_STAGES     (SYNC),
      .BLINK_HALF_CYC  (HALF),
      .LED_ACTIVE_HIGH (1'b1)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .slp3_i     (slp3),
      .slp5_n_i   (slp5_n),
      .msg_pend_i (msg),
      .led_grn_o  (led_grn),
      .led_yel_o  (led_yel)
   );

   // condition codes: 0 off, 1 run, 2 run+msg, 3 sleep, 4 sleep+msg
   function automatic logic [1:0] exp_leds(int st, int j);
      logic on;
      on = ((j / HALF) % 2) == 0;
      case (st)
         1: return 2'b10;
         2: return on ? 2'b10 : 2'b00;
         3: return 2'b01;
         4: return on ? 2'b01 : 2'b00;
         default: return 2'b00;
      endcase
   endfunction

   function automatic string req_of(int st);
      case (st)
         1: return "R2";
         2: return "R3/R7/R8";
         3: return "R4";
         4: return "R5/R7/R8";
         default: return "R1";
      endcase
   endfunction

   task automatic check(string req, logic [1:0] act, logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s at %0t: {grn,yel} actual=%b expected=%b", req, $time, act, exp);
      end
   endtask

   task automatic apply(int st, bit force_dc);
      int old;
      old = cur_st;
      case (st)
         0: begin
            slp5_n = 1'b0;
            slp3   = force_dc ? 1'b1 : 1'($urandom % 2);
            msg    = force_dc ? 1'b1 : 1'($urandom % 2);
         end
         1: begin slp5_n = 1'b1; slp3 = 1'b0; msg = 1'b0; end
         2: begin slp5_n = 1'b1; slp3 = 1'b0; msg = 1'b1; end
         3: begin slp5_n = 1'b1; slp3 = 1'b1; msg = 1'b0; end
         default: begin slp5_n = 1'b1; slp3 = 1'b1; msg = 1'b1; end
      endcase
      cur_st = st;
      for (int k = 1; k <= WIN; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (k == LAT - 1 && old != 2 && old != 4)
            check("R9 (old shown)", {led_grn, led_yel}, exp_leds(old, 0));
         else if (k >= LAT) begin
            check(req_of(st), {led_grn, led_yel}, exp_leds(st, k - LAT));
            // R6: never both lit
            check("R6", {1'b0, led_grn & led_yel}, 2'b00);
         end
      end
   endtask

   initial begin
      #(20 * 150000);
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int nxt;
      void'($urandom(32'd4242));
      repeat (5) @(negedge clk);
      // R10: dark during reset
      check("R10 (in reset)", {led_grn, led_yel}, 2'b00);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      check("R10 (after reset)", {led_grn, led_yel}, 2'b00);

      // directed sequence
      apply(1, 1'b0);
      apply(2, 1'b0);   // message only: restart lit
      apply(4, 1'b0);   // colour change while blinking
      apply(3, 1'b0);
      apply(0, 1'b1);   // R1: S3 and msg high, S5 low
      apply(2, 1'b0);
      apply(1, 1'b0);
      apply(0, 1'b0);
      apply(4, 1'b0);

      // random sequence of distinct conditions
      for (int n = 0; n < 40; n++) begin
         nxt = int'($urandom % 4);
         if (nxt >= cur_st) nxt++;
         apply(nxt, 1'b0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule